// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. It frees the bus after a transfer was cut short, after a power loss or after a reset. In those cases a target may still hold the data line low partway through a byte. When the block receives a recovery request, it toggles the clock line and checks the data line in every clock-high phase. It stops toggling as soon as the data line reads high. It then issues a start condition followed by a stop condition, which leaves every target on the bus in its idle state. If the data line is still low after the last permitted clock, the block releases both lines and reports failure.

Both lines are open-drain. An output-enable of 1 pulls the line low, and 0 releases it to the pull-up. The block builds every bus phase from whole quarter-bit periods. One quarter bit lasts `quarterDiv` system clocks, so software picks the bus speed by choosing the divider. Ordinary byte transfers are handled elsewhere.

Top module: `busrec_top`

## Requirements
- R1: During and after reset, with no request accepted, `sclOe`, `sdaOe`, `done` and `fail` are all 0.
- R2: A high `recoverReq` sampled while the block is idle starts a run. `sclOe` goes to 1 on that same clock edge, and `done` and `fail` both clear on that edge.
- R3: Each recovery clock drives SCL low (`sclOe`=1, `sdaOe`=0) for exactly 2 quarter bits, then releases SCL for exactly 2 quarter bits. A quarter bit is `quarterDiv` system clocks, and a `quarterDiv` of 0 acts as 1.
- R4: SDA is sampled through a two-stage synchronizer in the final system clock of each SCL-high phase. A high sample ends the pulsing at once.
- R5: No more than 9 recovery clocks are issued. If the sample after the ninth clock is still low, the block releases both lines, raises `fail`, and generates no start and no stop.
- R6: After a high sample, the block leaves both lines released for 1 more quarter bit, so SDA has been high with SCL high for 3 quarter bits in total. It then pulls SDA low while SCL is high (a start). It pulls SCL low 1 quarter bit later.
- R7: After the start, SCL stays low for 2 quarter bits with SDA low. SCL is then released, and 1 quarter bit later SDA is released while SCL is high (a stop).
- R8: `done` rises exactly 2 quarter bits after the stop, with both lines released.
- R9: `done` and `fail` are never high together. Each holds its value until the next accepted request.
- R10: A request that arrives while a run is in progress has no effect. It produces no extra run and no extra completion.
- R11: While `done` or `fail` is high, both output-enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| quarterDiv | input | DIV_W | System clocks per quarter bit (0 treated as 1) |
| recoverReq | input | 1 | Starts a recovery run when sampled high in idle |
| sdaIn | input | 1 | Level of the data line as seen at the pad |
| sclOe | output | 1 | 1 pulls the clock line low |
| sdaOe | output | 1 | 1 pulls the data line low |
| done | output | 1 | Run ended with start and stop generated |
| fail | output | 1 | Data line still low after the last recovery clock |

## Verification
An off-by-one in the phase timer shows up on the very first recovery clock, because the low time of `sclOe` no longer equals two divider periods. A wrong pulse count or a misplaced sample shows up at completion, either as the wrong number of recovery clocks or as `fail` where `done` was due. A state that decodes the wrong line drives shows up within one quarter bit, as a data-line edge while SCL is low or a start-to-stop spacing that is off. The scoreboard compares each of these per run, so a fault is reported within the run that exposes it.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LOW,
    ST_CLK_HIGH,
    ST_STA_SETUP,
    ST_STA_HOLD,
    ST_STO_LOW,
    ST_STO_SETUP,
    ST_BUS_FREE
  } recState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadTimer;  // start a new phase
    logic [1:0] quarters;   // phase length in quarter bits
    logic       clrPulses;
    logic       incPulses;
    logic       sclDrive;   // next value of sclOe
    logic       sdaDrive;   // next value of sdaOe
  } recStrobe_t;

endpackage

// File: rtl/busrec_datapath.sv
module busrec_datapath
  import busrec_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PULSE_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  recStrobe_t         strobe,
  input  logic [DIV_W-1:0]   quarterDiv,
  input  logic               sdaIn,
  output logic               phaseEnd,
  output logic [PULSE_W-1:0] pulseCnt,
  output logic               sdaSync,
  output logic               sclOe,
  output logic               sdaOe
);

  localparam int TIMER_W = DIV_W + 2;

  logic [DIV_W-1:0]       effDiv;
  logic [TIMER_W-1:0]     loadVal;
  logic [TIMER_W-1:0]     timer;
  logic [SYNC_STAGES-1:0] syncQ;

  assign effDiv   = (quarterDiv == '0) ? DIV_W'(1) : quarterDiv;
  assign loadVal  = TIMER_W'(effDiv) * TIMER_W'(strobe.quarters) - TIMER_W'(1);
  assign phaseEnd = (timer == '0);
  assign sdaSync  = syncQ[SYNC_STAGES-1];

  // Phase timer: a loaded phase lasts quarters*effDiv cycles
  always_ff @(posedge clk) begin
    if (!rstN)                 timer <= '0;
    else if (strobe.loadTimer) timer <= loadVal;
    else if (timer != '0)      timer <= timer - TIMER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (strobe.clrPulses) pulseCnt <= '0;
    else if (strobe.incPulses) pulseCnt <= pulseCnt + PULSE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= strobe.sclDrive;
      sdaOe <= strobe.sdaDrive;
    end
  end

  // SDA synchronizer, idle high
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdaIn};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= sdaIn;
      end
    end
  endgenerate

endmodule

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
  import busrec_pkg::*;
#(
  parameter int MAX_PULSES = 9,
  parameter int PULSE_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               recoverReq,
  input  logic               phaseEnd,
  input  logic [PULSE_W-1:0] pulseCnt,
  input  logic               sdaSync,
  output recStrobe_t         strobe,
  output logic               done,
  output logic               fail
);

  localparam logic [PULSE_W-1:0] LAST_PULSE = PULSE_W'(MAX_PULSES - 1);

  recState_t state, stateNext;
  logic      accept, setDone, setFail;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    accept    = 1'b0;
    setDone   = 1'b0;
    setFail   = 1'b0;
    unique case (state)
      ST_IDLE: if (recoverReq) begin
        accept           = 1'b1;
        stateNext        = ST_CLK_LOW;
        strobe.loadTimer = 1'b1;
        strobe.quarters  = 2'd2;
        strobe.clrPulses = 1'b1;
      end
      ST_CLK_LOW: if (phaseEnd) begin
        stateNext        = ST_CLK_HIGH;
        strobe.loadTimer = 1'b1;
        strobe.quarters  = 2'd2;
      end
      ST_CLK_HIGH: if (phaseEnd) begin
        if (sdaSync) begin
          stateNext        = ST_STA_SETUP;
          strobe.loadTimer = 1'b1;
          strobe.quarters  = 2'd1;
        end else if (pulseCnt == LAST_PULSE) begin
          stateNext = ST_IDLE;
          setFail   = 1'b1;
        end else begin
          stateNext        = ST_CLK_LOW;
          strobe.loadTimer = 1'b1;
          strobe.quarters  = 2'd2;
          strobe.incPulses = 1'b1;
        end
      end
      ST_STA_SETUP: if (phaseEnd) begin
        stateNext        = ST_STA_HOLD;
        strobe.loadTimer = 1'b1;
        strobe.quarters  = 2'd1;
      end
      ST_STA_HOLD: if (phaseEnd) begin
        stateNext        = ST_STO_LOW;
        strobe.loadTimer = 1'b1;
        strobe.quarters  = 2'd2;
      end
      ST_STO_LOW: if (phaseEnd) begin
        stateNext        = ST_STO_SETUP;
        strobe.loadTimer = 1'b1;
        strobe.quarters  = 2'd1;
      end
      ST_STO_SETUP: if (phaseEnd) begin
        stateNext        = ST_BUS_FREE;
        strobe.loadTimer = 1'b1;
        strobe.quarters  = 2'd2;
      end
      ST_BUS_FREE: if (phaseEnd) begin
        stateNext = ST_IDLE;
        setDone   = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
    // Line drives follow the state being entered
    strobe.sclDrive = (stateNext == ST_CLK_LOW) || (stateNext == ST_STO_LOW);
    strobe.sdaDrive = (stateNext == ST_STA_HOLD) || (stateNext == ST_STO_LOW) ||
                      (stateNext == ST_STO_SETUP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        done <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (setDone) done <= 1'b1;
        if (setFail) fail <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/busrec_top.sv
module busrec_top
  import busrec_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] quarterDiv,
  input  logic             recoverReq,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             done,
  output logic             fail
);

  localparam int PULSE_W = $clog2(MAX_PULSES + 1);

  recStrobe_t         strobe;
  logic               phaseEnd;
  logic               sdaSync;
  logic [PULSE_W-1:0] pulseCnt;

  busrec_ctrl #(
    .MAX_PULSES(MAX_PULSES),
    .PULSE_W   (PULSE_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .recoverReq(recoverReq),
    .phaseEnd  (phaseEnd),
    .pulseCnt  (pulseCnt),
    .sdaSync   (sdaSync),
    .strobe    (strobe),
    .done      (done),
    .fail      (fail)
  );

  busrec_datapath #(
    .DIV_W      (DIV_W),
    .PULSE_W    (PULSE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .quarterDiv(quarterDiv),
    .sdaIn     (sdaIn),
    .phaseEnd  (phaseEnd),
    .pulseCnt  (pulseCnt),
    .sdaSync   (sdaSync),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe)
  );

endmodule

// File: rtl/busrec_checker.sv
module busrec_checker #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rstN,
  input logic sclOe,
  input logic sdaOe,
  input logic done,
  input logic fail
);

  localparam int CNT_W = $clog2(MAX_PULSES + 2) + 1;

  logic [CNT_W-1:0] pulseSeen;
  logic             sclPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseSeen <= '0;
      sclPrev   <= 1'b0;
    end else begin
      sclPrev <= sclOe;
      if (done || fail)                    pulseSeen <= '0;
      else if (sclOe && !sclPrev && !sdaOe) pulseSeen <= pulseSeen + CNT_W'(1);
    end
  end

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail)); // R9

  AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclOe); // R6

  AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclOe); // R7

  AST_FAIL_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (!sclOe && !sdaOe)); // R5

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseSeen <= CNT_W'(MAX_PULSES)); // R5

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sclOe && !sdaOe)); // R11

endmodule

bind busrec_top busrec_checker #(.MAX_PULSES(MAX_PULSES)) chk_i (
  .clk  (clk),
  .rstN (rstN),
  .sclOe(sclOe),
  .sdaOe(sdaOe),
  .done (done),
  .fail (fail)
);

// File: tb/busrec_top_tb_top.sv
module busrec_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] quarterDiv = 8'd1;
  logic       recoverReq = 1'b0;
  logic       sdaIn;
  logic       sclOe, sdaOe, done, fail;

  always #2 clk = ~clk;  // 250 MHz

  // Target model: holds SDA low until it has seen more than holdPulses SCL falls
  int holdPulses = 0;
  int sclFalls   = 0;
  assign sdaIn = !sdaOe && !(sclFalls <= holdPulses);

  busrec_top dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .quarterDiv(quarterDiv),
    .recoverReq(recoverReq),
    .sdaIn     (sdaIn),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe),
    .done      (done),
    .fail      (fail)
  );

  typedef struct {
    int pulses;
    bit isDone;
    int div;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int launched = 0;
  int completed = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures every phase and pops the expectation at completion
  initial begin
    int cyc = 0;
    int tSclRise = 0, tSclFall = 0, tSdaRise = 0, tSdaFall = 0;
    int runPulses = 0, starts = 0, stops = 0, div = 1;
    logic pScl = 1'b0, pSda = 1'b0, pFlag = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      div = (expQ.size() > 0) ? expQ[0].div : 1;
      if (rstN) begin
        if (sclOe && !pScl) begin
          sclFalls++;
          if (!sdaOe) begin
            runPulses++;
            if (runPulses > 1) check("R3 high phase", cyc - tSclFall, 2 * div);
          end else begin
            check("R6 start hold", cyc - tSdaRise, div);
          end
          tSclRise = cyc;
        end
        if (!sclOe && pScl) begin
          if (!sdaOe) check("R3 low phase", cyc - tSclRise, 2 * div);
          else        check("R7 stop low", cyc - tSclRise, 2 * div);
          tSclFall = cyc;
        end
        if (sdaOe && !pSda) begin
          starts++;
          check("R6 start setup", cyc - tSclFall, 3 * div);
          tSdaRise = cyc;
        end
        if (!sdaOe && pSda) begin
          stops++;
          check("R7 stop setup", cyc - tSclFall, div);
          tSdaFall = cyc;
        end
        if ((done || fail) && !pFlag) begin
          completed++;
          if (expQ.size() == 0) begin
            check("R10 unexpected completion", 1, 0);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check("R4 R5 pulse count", runPulses, e.pulses);
            check("R8 done", int'(done), int'(e.isDone));
            check("R5 fail", int'(fail), int'(!e.isDone));
            if (e.isDone) begin
              check("R6 starts", starts, 1);
              check("R7 stops", stops, 1);
              check("R8 bus free", cyc - tSdaFall, 2 * e.div);
            end else begin
              check("R5 no start", starts, 0);
              check("R5 no stop", stops, 0);
              check("R5 released", int'(sclOe | sdaOe), 0);
            end
          end
          runPulses = 0;
          starts    = 0;
          stops     = 0;
          sclFalls  = 0;
        end
      end
      pScl  = sclOe;
      pSda  = sdaOe;
      pFlag = done || fail;
    end
  end

  // Driver: pushes the expectation, issues the request, waits for the end
  task automatic runRecovery(int div, int hold, bit extraReq);
    expItem_t e;
    bit expDone;
    @(negedge clk);
    expDone    = (hold <= 8);
    e.pulses   = expDone ? hold + 1 : 9;
    e.isDone   = expDone;
    e.div      = (div == 0) ? 1 : div;
    expQ.push_back(e);
    launched++;
    quarterDiv = 8'(div);
    holdPulses = hold;
    recoverReq = 1'b1;
    @(negedge clk);
    recoverReq = 1'b0;
    check("R2 scl pulled", int'(sclOe), 1);
    check("R9 flags cleared", int'(done | fail), 0);
    if (extraReq) begin
      repeat (5) @(negedge clk);
      recoverReq = 1'b1;
      @(negedge clk);
      recoverReq = 1'b0;
    end
    while (!(done || fail)) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R9 flag held", int'(done), int'(expDone));
    check("R9 exclusive", int'(done & fail), 0);
    check("R11 idle lines", int'(sclOe | sdaOe), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 sclOe", int'(sclOe), 0);
    check("R1 sdaOe", int'(sdaOe), 0);
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", int'(sclOe | sdaOe | done | fail), 0);

    runRecovery(3, 0, 1'b0);   // SDA free at first sample
    runRecovery(2, 4, 1'b0);   // five clocks
    runRecovery(1, 8, 1'b0);   // released on the last allowed clock
    runRecovery(2, 9, 1'b0);   // stuck: fail
    runRecovery(0, 2, 1'b0);   // divider 0 acts as 1
    runRecovery(4, 3, 1'b1);   // R10: second request while busy
    repeat (60) @(negedge clk);
    check("R10 no extra run", int'(sclOe), 0);
    check("R10 done kept", int'(done), 1);
    check("R10 completions", completed, launched);
    check("R10 queue drained", expQ.size(), 0);
    runRecovery(1, 20, 1'b0);  // fail after a done

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule